// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is a word-addressed general-purpose I/O controller with one or two channels of pins. Each channel offers a data register and a direction register to a simple CPU-side register bus that has a write strobe, a read strobe and read data one clock after the strobe. Every pin has three wires: a driven value, an input value and a tri-state enable. The input is passed through a two-flop synchronizer before any read sees it.

Each channel is fixed when the block is built. It can be a bidirectional channel, an input-only channel or an output-only channel. Parameters also set the output value the channel holds after reset and how data reads treat pins that are outputs. With the default read-back policy, a data read always returns the live synchronized pin level, so an output pin that is held low from outside reads low. The other policy returns the stored drive value for outputs. Writes to the data register always land in the output register. Software can therefore preload a level and then switch the pin to an output, and the pin drives the new level from its first cycle.

Top module: `gpio_ctrl`

## Requirements
- R1: Word addresses are 0 = channel 1 data, 1 = channel 1 direction, 2 = channel 2 data and 3 = channel 2 direction. Read data appears on the clock after the read strobe, and `bus_rdata` is zero after any cycle without a read strobe.
- R2: A direction bit of 1 makes the pin an input (tri-state enable 1). A bit of 0 makes it an output. On a bidirectional channel the direction register resets to all ones, and reading it returns the current enables.
- R3: A data write loads the output register whatever the direction bits are, and the driven pins show the new value on the next clock.
- R4: Under the pin read-back policy, a data read returns the synchronized input wires for every pin, including the output pins.
- R5: Under the driven read-back policy, a data read returns the stored output bit for pins whose direction bit is 0 and the synchronized input for pins whose direction bit is 1.
- R6: An output-only channel holds its tri-state enables at 0 and ignores direction writes. Its direction reads return 0, its data reads return the output register, and its input wires are ignored.
- R7: An input-only channel drives its output wires at 0 and its tri-state enables at all ones. It ignores data and direction writes, its data reads return the synchronized inputs, and its direction reads return all ones.
- R8: After reset the output register of each channel that can drive holds the channel's default output parameter.
- R9: A direction write never changes the output register. The output wires change only on a data write.
- R10: An input change is seen by a read issued two cycles after the change, and not by a read issued zero or one cycle after it.
- R11: Reads of addresses 4 and above, and of addresses 2 and 3 when only one channel is built, return zero. Writes to those addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, valid the cycle after `bus_rd` |
| ch1_in | input | CH1_PINS | Channel 1 pin inputs |
| ch1_out | output | CH1_PINS | Channel 1 driven values |
| ch1_tri | output | CH1_PINS | Channel 1 tri-state enables (1 = released) |
| ch2_in | input | CH2_PINS | Channel 2 pin inputs |
| ch2_out | output | CH2_PINS | Channel 2 driven values |
| ch2_tri | output | CH2_PINS | Channel 2 tri-state enables (1 = released) |

## Verification
The bench builds three copies with 8-pin channels. The first has a bidirectional channel 1 with pin read-back and an output-only channel 2. The second has a bidirectional channel 1 with driven read-back and an input-only channel 2. The third is built with a single channel. This set of builds covers both read-back policies, both one-way channel kinds, non-zero reset defaults and the absent second channel. The input pins are driven independently of the outputs, so a mismatch between driven and sensed levels shows which source each read returns.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

    typedef enum logic [1:0] {
        CH_BIDIR   = 2'd0,
        CH_ALL_IN  = 2'd1,
        CH_ALL_OUT = 2'd2
    } ch_mode_e;

    typedef enum logic {
        RB_PIN    = 1'b0,
        RB_DRIVEN = 1'b1
    } rb_mode_e;

    localparam int REGS_PER_CH = 2;

    typedef struct packed {
        logic hit;     // address maps to a built channel
        logic ch;      // 0 = channel 1, 1 = channel 2
        logic is_dir;  // 1 = direction register, 0 = data register
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input int unsigned addr, input int unsigned num_ch);
        reg_sel_t s;
        s.hit    = (addr < num_ch * REGS_PER_CH);
        s.ch     = addr[1];
        s.is_dir = addr[0];
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1, stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;

    // cycles since reset, saturating, so the check never looks before reset
    logic [1:0] live_cnt;
    always_ff @(posedge clk) begin
        if (rst)                 live_cnt <= '0;
        else if (live_cnt != 2'd2) live_cnt <= live_cnt + 2'd1;
    end

    AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (rst)
        (live_cnt == 2'd2) |-> (q == $past(d, 2)));   // R10

endmodule

// File: rtl/gpio_channel.sv
module gpio_channel
    import gpio_ctrl_pkg::*;
#(
    parameter int              PINS        = 8,
    parameter ch_mode_e        MODE        = CH_BIDIR,
    parameter rb_mode_e        READBACK    = RB_PIN,
    parameter logic [PINS-1:0] DEFAULT_OUT = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            data_we,
    input  logic            dir_we,
    input  logic [PINS-1:0] wdata,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] pin_out,
    output logic [PINS-1:0] pin_tri,
    output logic [PINS-1:0] data_rd,
    output logic [PINS-1:0] dir_rd
);
    localparam bit HAS_OUT = (MODE != CH_ALL_IN);
    localparam bit HAS_DIR = (MODE == CH_BIDIR);

    logic [PINS-1:0] in_sync;
    logic [PINS-1:0] out_q;
    logic [PINS-1:0] dir_q;

    gpio_sync #(.W(PINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (in_sync)
    );

    generate
        if (HAS_OUT) begin : g_out
            always_ff @(posedge clk) begin
                if (rst)          out_q <= DEFAULT_OUT;
                else if (data_we) out_q <= wdata;
            end
        end else begin : g_no_out
            assign out_q = '0;
        end

        if (HAS_DIR) begin : g_dir
            always_ff @(posedge clk) begin
                if (rst)         dir_q <= '1;
                else if (dir_we) dir_q <= wdata;
            end
        end else if (MODE == CH_ALL_IN) begin : g_dir_in
            assign dir_q = '1;
        end else begin : g_dir_out
            assign dir_q = '0;
        end

        if (MODE == CH_ALL_OUT) begin : g_rd_out
            assign data_rd = out_q;
        end else if (MODE == CH_BIDIR && READBACK == RB_DRIVEN) begin : g_rd_mix
            assign data_rd = (dir_q & in_sync) | (~dir_q & out_q);
        end else begin : g_rd_pin
            assign data_rd = in_sync;
        end
    endgenerate

    assign pin_out = out_q;
    assign pin_tri = dir_q;
    assign dir_rd  = dir_q;

    AST_OUT_ONLY_ON_DATA_WR: assert property (@(posedge clk) disable iff (rst)
        !data_we |=> $stable(pin_out));   // R9

endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int                  ADDR_W       = 3,
    parameter int                  DATA_W       = 32,
    parameter int                  NUM_CH       = 2,
    parameter int                  CH1_PINS     = 32,
    parameter ch_mode_e            CH1_MODE     = CH_BIDIR,
    parameter rb_mode_e            CH1_READBACK = RB_PIN,
    parameter logic [CH1_PINS-1:0] CH1_DEFAULT  = '0,
    parameter int                  CH2_PINS     = 32,
    parameter ch_mode_e            CH2_MODE     = CH_BIDIR,
    parameter rb_mode_e            CH2_READBACK = RB_PIN,
    parameter logic [CH2_PINS-1:0] CH2_DEFAULT  = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_rd,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [CH1_PINS-1:0] ch1_in,
    output logic [CH1_PINS-1:0] ch1_out,
    output logic [CH1_PINS-1:0] ch1_tri,
    input  logic [CH2_PINS-1:0] ch2_in,
    output logic [CH2_PINS-1:0] ch2_out,
    output logic [CH2_PINS-1:0] ch2_tri
);
    localparam int MAX_CH = 2;

    reg_sel_t            sel;
    logic [MAX_CH-1:0]   data_we, dir_we;
    logic [DATA_W-1:0]   data_word [MAX_CH];
    logic [DATA_W-1:0]   dir_word  [MAX_CH];
    logic [DATA_W-1:0]   rd_next;

    assign sel = decode_addr(int'(bus_addr), NUM_CH);

    generate
        for (genvar i = 0; i < MAX_CH; i++) begin : g_we
            assign data_we[i] = bus_wr && sel.hit && (sel.ch == 1'(i)) && !sel.is_dir;
            assign dir_we[i]  = bus_wr && sel.hit && (sel.ch == 1'(i)) &&  sel.is_dir;
        end
    endgenerate

    logic [CH1_PINS-1:0] c1_data, c1_dir;

    gpio_channel #(
        .PINS(CH1_PINS), .MODE(CH1_MODE), .READBACK(CH1_READBACK), .DEFAULT_OUT(CH1_DEFAULT)
    ) u_ch1 (
        .clk(clk), .rst(rst), .data_we(data_we[0]), .dir_we(dir_we[0]),
        .wdata(bus_wdata[CH1_PINS-1:0]), .pin_in(ch1_in),
        .pin_out(ch1_out), .pin_tri(ch1_tri), .data_rd(c1_data), .dir_rd(c1_dir)
    );

    always_comb begin
        data_word[0] = '0;
        dir_word[0]  = '0;
        data_word[0][CH1_PINS-1:0] = c1_data;
        dir_word[0][CH1_PINS-1:0]  = c1_dir;
    end

    generate
        if (NUM_CH == 2) begin : g_ch2
            logic [CH2_PINS-1:0] c2_data, c2_dir;

            gpio_channel #(
                .PINS(CH2_PINS), .MODE(CH2_MODE), .READBACK(CH2_READBACK), .DEFAULT_OUT(CH2_DEFAULT)
            ) u_ch2 (
                .clk(clk), .rst(rst), .data_we(data_we[1]), .dir_we(dir_we[1]),
                .wdata(bus_wdata[CH2_PINS-1:0]), .pin_in(ch2_in),
                .pin_out(ch2_out), .pin_tri(ch2_tri), .data_rd(c2_data), .dir_rd(c2_dir)
            );

            always_comb begin
                data_word[1] = '0;
                dir_word[1]  = '0;
                data_word[1][CH2_PINS-1:0] = c2_data;
                dir_word[1][CH2_PINS-1:0]  = c2_dir;
            end
        end else begin : g_no_ch2
            assign ch2_out      = '0;
            assign ch2_tri      = '1;
            assign data_word[1] = '0;
            assign dir_word[1]  = '0;
        end
    endgenerate

    always_comb begin
        rd_next = '0;
        if (sel.hit)
            rd_next = sel.is_dir ? dir_word[sel.ch] : data_word[sel.ch];
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
        else             bus_rdata <= '0;
    end

    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == '0));   // R1

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (int'(bus_addr) >= NUM_CH * REGS_PER_CH)) |=> (bus_rdata == '0));   // R11

endmodule

// File: tb/gpio_ctrl_bench.sv
module gpio_ctrl_bench;
    import gpio_ctrl_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;   // 125 MHz

    logic [2:0]  addr  = '0;
    logic [31:0] wdata = '0;
    logic [2:0]  wr    = '0;
    logic [2:0]  rd    = '0;

    logic [31:0] a_rdata, b_rdata, c_rdata;
    logic [7:0] a1_in = '0, a2_in = '0, b1_in = '0, b2_in = '0, c1_in = '0, c2_in = '0;
    logic [7:0] a1_out, a1_tri, a2_out, a2_tri;
    logic [7:0] b1_out, b1_tri, b2_out, b2_tri;
    logic [7:0] c1_out, c1_tri, c2_out, c2_tri;

    gpio_ctrl #(.NUM_CH(2), .CH1_PINS(8), .CH1_MODE(CH_BIDIR), .CH1_READBACK(RB_PIN),
                .CH1_DEFAULT(8'h5A), .CH2_PINS(8), .CH2_MODE(CH_ALL_OUT), .CH2_DEFAULT(8'hA5))
    u_gpio_ctrl (.clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr[0]), .bus_wdata(wdata),
                 .bus_rd(rd[0]), .bus_rdata(a_rdata), .ch1_in(a1_in), .ch1_out(a1_out),
                 .ch1_tri(a1_tri), .ch2_in(a2_in), .ch2_out(a2_out), .ch2_tri(a2_tri));

    gpio_ctrl #(.NUM_CH(2), .CH1_PINS(8), .CH1_MODE(CH_BIDIR), .CH1_READBACK(RB_DRIVEN),
                .CH1_DEFAULT(8'h0F), .CH2_PINS(8), .CH2_MODE(CH_ALL_IN))
    u_gpio_ctrl_b (.clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr[1]), .bus_wdata(wdata),
                   .bus_rd(rd[1]), .bus_rdata(b_rdata), .ch1_in(b1_in), .ch1_out(b1_out),
                   .ch1_tri(b1_tri), .ch2_in(b2_in), .ch2_out(b2_out), .ch2_tri(b2_tri));

    gpio_ctrl #(.NUM_CH(1), .CH1_PINS(8), .CH2_PINS(8))
    u_gpio_ctrl_c (.clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr[2]), .bus_wdata(wdata),
                   .bus_rd(rd[2]), .bus_rdata(c_rdata), .ch1_in(c1_in), .ch1_out(c1_out),
                   .ch1_tri(c1_tri), .ch2_in(c2_in), .ch2_out(c2_out), .ch2_tri(c2_tri));

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        int          inst;
        logic [31:0] exp;
        string       tag;
    } rd_item_t;
    rd_item_t exp_q[$];

    logic rd_d = 1'b0;
    always @(posedge clk) rd_d <= |rd;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per completed read
    always @(negedge clk) begin
        if (rd_d && !done) begin
            rd_item_t it;
            logic [31:0] act;
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R1 unexpected read result actual=%h expected=none", a_rdata);
            end else begin
                it = exp_q.pop_front();
                act = (it.inst == 0) ? a_rdata : (it.inst == 1) ? b_rdata : c_rdata;
                check(it.tag, act, it.exp);
            end
        end
    end

    task automatic wr_reg(int inst, int a, logic [31:0] d);
        addr = 3'(a); wdata = d; wr[inst] = 1'b1;
        @(negedge clk);
        wr[inst] = 1'b0;
    endtask

    task automatic rd_reg(int inst, int a, logic [31:0] exp, string tag);
        rd_item_t it;
        it.inst = inst; it.exp = exp; it.tag = tag;
        exp_q.push_back(it);
        addr = 3'(a); rd[inst] = 1'b1;
        @(negedge clk);
        rd[inst] = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        check("R8 A ch1 default out", 32'(a1_out), 32'h5A);
        check("R8 A ch2 default out", 32'(a2_out), 32'hA5);
        check("R2 A ch1 tri reset", 32'(a1_tri), 32'hFF);
        check("R6 A ch2 tri held out", 32'(a2_tri), 32'h00);
        check("R7 B ch2 out held zero", 32'(b2_out), 32'h00);
        check("R7 B ch2 tri held in", 32'(b2_tri), 32'hFF);
        check("R8 B ch1 default out", 32'(b1_out), 32'h0F);
        check("R1 idle rdata", a_rdata, 32'h0);
        rd_reg(0, 1, 32'hFF, "R2 A ch1 dir read reset");
        rd_reg(0, 3, 32'h00, "R6 A ch2 dir read");

        // R3 / R9: preload while input, then enable outputs
        wr_reg(0, 0, 32'h3C);
        check("R3 A data write while input", 32'(a1_out), 32'h3C);
        check("R2 A tri unchanged by data write", 32'(a1_tri), 32'hFF);
        wr_reg(0, 1, 32'hF0);
        check("R9 A dir write keeps out", 32'(a1_out), 32'h3C);
        check("R2 A tri after dir write", 32'(a1_tri), 32'hF0);
        rd_reg(0, 1, 32'hF0, "R2 A dir readback");
        @(negedge clk);
        check("R1 rdata zero after idle cycle", a_rdata, 32'h0);

        // R4: pin read-back returns inputs even on output pins
        a1_in = 8'h81;
        settle();
        rd_reg(0, 0, 32'h81, "R4 A data read returns pins");

        // R5: driven read-back
        b1_in = 8'hA5;
        settle();
        rd_reg(1, 0, 32'hA5, "R5 B all pins input");
        wr_reg(1, 0, 32'h3C);
        wr_reg(1, 1, 32'hF0);
        check("R9 B dir write keeps out", 32'(b1_out), 32'h3C);
        rd_reg(1, 0, 32'hAC, "R5 B mixed read-back");

        // R6: output-only channel
        a2_in = 8'hFF;
        wr_reg(0, 2, 32'h66);
        check("R6 A ch2 out after write", 32'(a2_out), 32'h66);
        wr_reg(0, 3, 32'hFF);
        check("R6 A ch2 tri ignores write", 32'(a2_tri), 32'h00);
        settle();
        rd_reg(0, 2, 32'h66, "R6 A ch2 data reads out reg");
        rd_reg(0, 3, 32'h00, "R6 A ch2 dir read after write");

        // R7: input-only channel
        b2_in = 8'h3E;
        wr_reg(1, 2, 32'hFF);
        check("R7 B ch2 out ignores write", 32'(b2_out), 32'h00);
        wr_reg(1, 3, 32'h00);
        check("R7 B ch2 tri ignores write", 32'(b2_tri), 32'hFF);
        settle();
        rd_reg(1, 2, 32'h3E, "R7 B ch2 data reads pins");
        rd_reg(1, 3, 32'hFF, "R7 B ch2 dir read");

        // R10: synchronizer latency
        a1_in = 8'h18;
        rd_reg(0, 0, 32'h81, "R10 read at change sees old");
        rd_reg(0, 0, 32'h81, "R10 read one cycle later sees old");
        rd_reg(0, 0, 32'h18, "R10 read two cycles later sees new");

        // R11: unmapped addresses
        wr_reg(0, 4, 32'h00);
        wr_reg(0, 5, 32'hFF);
        wr_reg(0, 6, 32'h11);
        check("R11 A out unchanged by unmapped write", 32'(a1_out), 32'h3C);
        check("R11 A tri unchanged by unmapped write", 32'(a1_tri), 32'hF0);
        check("R11 A ch2 out unchanged", 32'(a2_out), 32'h66);
        for (int k = 4; k < 8; k++) rd_reg(0, k, 32'h0, "R11 A unmapped read");
        c1_in = 8'h77;
        wr_reg(2, 2, 32'hFF);
        wr_reg(2, 3, 32'h00);
        check("R11 C ch1 out unchanged by ch2 write", 32'(c1_out), 32'h00);
        check("R11 C ch1 tri unchanged by ch2 write", 32'(c1_tri), 32'hFF);
        rd_reg(2, 2, 32'h0, "R11 C absent ch2 data read");
        rd_reg(2, 3, 32'h0, "R11 C absent ch2 dir read");
        rd_reg(2, 0, 32'h77, "R4 C ch1 data read");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; failures++;
            $display("FAIL R1 reads left unchecked actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule